// File: doc/BRIEF.md
# Product-Term Array with Grouped OR Sums

This block evaluates sum-of-products logic for a small programmable logic core. It takes sixteen array signals: eight dedicated inputs and eight macrocell feedbacks. It buffers each signal in true and complement form, which gives thirty-two array columns. It then evaluates sixty-four product terms against a connection matrix held in flip-flops. The terms are grouped eight at a time, and each group drives one OR sum for its output cell.

The product terms and the sums are purely combinational. The connection matrix changes only at a rising clock edge, through a single-row load port. Cleared cells and clashing connections follow floating-gate array conventions:
- A term that has no connected column reads HIGH.
- A term that is connected to both polarities of any one signal reads LOW.

When the core runs without registers, the clock pin and the output-enable pin become ordinary array inputs. They enter the array through the feedback slots of the last cell and the first cell.

Top module: `sop_plane`

## Requirements
- R1: Array signal j (0..7) is `ded_in[j]` and signal j (8..15) is `fb_in[j-8]`. Signal j drives column 2j in true form and column 2j+1 in complement form. Bit c of a row value set to 1 connects column c to that term.
- R2: Term t (0..63) is evaluated from row t of the matrix. `sum_out[k]` is the OR of terms 8k to 8k+7.
- R3: A term whose row value is all zeros reads 1.
- R4: A term connected to both column 2j and column 2j+1 for any j reads 0, whatever the inputs.
- R5: With `comb_mode`=1, signal 15 is taken from `pin_clk_in` and signal 8 is taken from `pin_oe_in`. With `comb_mode`=0, both come from `fb_in` and the two pins have no effect.
- R6: After reset every row connects all 32 columns, so `term_out` and `sum_out` read all zeros.
- R7: At a rising edge with `cfg_valid`=1 and `prog_en`=1, row `cfg_row` takes `cfg_bits`. The new value shows on the outputs after that edge. `cfg_ready` is always 1.
- R8: A transfer with `prog_en`=0 changes no row.
- R9: `term_out` and `sum_out` follow `ded_in`, `fb_in` and the pins within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the matrix load port |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Allows row writes |
| cfg_valid | input | 1 | Row write request |
| cfg_ready | output | 1 | Always 1; no back-pressure is ever applied |
| cfg_row | input | 6 | Row (term) index to write |
| cfg_bits | input | 32 | Connection mask for that row |
| ded_in | input | 8 | Dedicated array inputs |
| fb_in | input | 8 | Macrocell feedbacks, cell 0 to cell 7 |
| pin_clk_in | input | 1 | Clock pin used as a data input |
| pin_oe_in | input | 1 | Output-enable pin used as a data input |
| comb_mode | input | 1 | Non-registered operation; reroutes the two pins |
| term_out | output | 64 | Product terms |
| sum_out | output | 8 | OR of each group of eight terms |

## Verification
A corrupted row of the matrix shows on the ports as soon as its term is sensitised. Either a term that should be HIGH stays LOW, or its group sum flips. Both show in the same cycle as the input change. A write that lands in the wrong row, or that lands despite a cleared enable, shows from the first falling edge after the clock edge that stored it. A wrong column order or pin routing shows at once as a term that ignores the input meant to steer it.

// File: rtl/sop_plane_pkg.sv
package sop_plane_pkg;
  localparam int NUM_SIG   = 16;
  localparam int NUM_COL   = 2 * NUM_SIG;
  localparam int NUM_TERM  = 64;
  localparam int NUM_OUT   = 8;
  localparam int TERM_PER  = NUM_TERM / NUM_OUT;
  localparam int ROW_AW    = $clog2(NUM_TERM);
endpackage

// File: rtl/sop_plane_colbuf.sv
module sop_plane_colbuf #(
  parameter int NSIG = 16,
  localparam int NDED = NSIG / 2,
  localparam int NCOL = 2 * NSIG
) (
  input  logic [NDED-1:0] ded_in,
  input  logic [NDED-1:0] fb_in,
  input  logic            pin_clk_in,
  input  logic            pin_oe_in,
  input  logic            comb_mode,
  output logic [NCOL-1:0] cols
);
  logic [NSIG-1:0] sig;

  always_comb begin
    sig = {fb_in, ded_in};
    if (comb_mode) begin
      sig[NSIG-1] = pin_clk_in;
      sig[NDED]   = pin_oe_in;
    end
  end

  for (genvar j = 0; j < NSIG; j++) begin : g_pair
    assign cols[2*j]   = sig[j];
    assign cols[2*j+1] = ~sig[j];
  end
endmodule

// File: rtl/sop_plane_store.sv
module sop_plane_store #(
  parameter int NROW = 64,
  parameter int NCOL = 32,
  localparam int AW = $clog2(NROW)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_en,
  input  logic                      cfg_valid,
  input  logic [AW-1:0]             cfg_row,
  input  logic [NCOL-1:0]           cfg_bits,
  output logic [NROW-1:0][NCOL-1:0] rows
);
  logic wr_go;
  assign wr_go = cfg_valid && prog_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows <= '1;
    end else if (wr_go) begin
      rows[cfg_row] <= cfg_bits;
    end
  end

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (rows[$past(cfg_row)] == $past(cfg_bits)));

  assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !prog_en) |=> $stable(rows));
endmodule

// File: rtl/sop_plane_term.sv
module sop_plane_term #(
  parameter int NCOL = 32,
  localparam int NSIG = NCOL / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCOL-1:0] cols,
  input  logic [NCOL-1:0] conn,
  output logic            term
);
  assign term = &(cols | ~conn);

  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int j = 0; j < NSIG; j++) begin
      if (conn[2*j] && conn[2*j+1]) clash = 1'b1;
    end
  end

  assert_empty_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conn == '0) |-> term);

  assert_clash_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> !term);
endmodule

// File: rtl/sop_plane_or.sv
module sop_plane_or #(
  parameter int NTERM = 64,
  parameter int NOUT  = 8,
  localparam int PER  = NTERM / NOUT
) (
  input  logic [NTERM-1:0] terms,
  output logic [NOUT-1:0]  sums
);
  for (genvar k = 0; k < NOUT; k++) begin : g_grp
    assign sums[k] = |terms[k*PER +: PER];
  end
endmodule

// File: rtl/sop_plane.sv
module sop_plane
  import sop_plane_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_en,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [ROW_AW-1:0]   cfg_row,
  input  logic [NUM_COL-1:0]  cfg_bits,
  input  logic [NUM_SIG/2-1:0] ded_in,
  input  logic [NUM_SIG/2-1:0] fb_in,
  input  logic                pin_clk_in,
  input  logic                pin_oe_in,
  input  logic                comb_mode,
  output logic [NUM_TERM-1:0] term_out,
  output logic [NUM_OUT-1:0]  sum_out
);
  logic [NUM_COL-1:0]                cols;
  logic [NUM_TERM-1:0][NUM_COL-1:0]  rows;

  assign cfg_ready = 1'b1;

  sop_plane_colbuf #(.NSIG(NUM_SIG)) u_colbuf (
    .ded_in(ded_in), .fb_in(fb_in), .pin_clk_in(pin_clk_in),
    .pin_oe_in(pin_oe_in), .comb_mode(comb_mode), .cols(cols));

  sop_plane_store #(.NROW(NUM_TERM), .NCOL(NUM_COL)) u_store (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_valid(cfg_valid),
    .cfg_row(cfg_row), .cfg_bits(cfg_bits), .rows(rows));

  for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
    sop_plane_term #(.NCOL(NUM_COL)) u_term (
      .clk(clk), .rst_n(rst_n), .cols(cols), .conn(rows[t]),
      .term(term_out[t]));
  end

  sop_plane_or #(.NTERM(NUM_TERM), .NOUT(NUM_OUT)) u_or (
    .terms(term_out), .sums(sum_out));
endmodule

// File: tb/sop_plane_test.sv
module sop_plane_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_en = 0, cfg_valid = 0, pin_clk_in = 0, pin_oe_in = 0, comb_mode = 0;
  logic [5:0] cfg_row = '0;
  logic [31:0] cfg_bits = '0;
  logic [7:0] ded_in = '0, fb_in = '0;
  logic cfg_ready;
  logic [63:0] term_out;
  logic [7:0] sum_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sop_plane uut (.clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_row(cfg_row), .cfg_bits(cfg_bits), .ded_in(ded_in),
    .fb_in(fb_in), .pin_clk_in(pin_clk_in), .pin_oe_in(pin_oe_in),
    .comb_mode(comb_mode), .term_out(term_out), .sum_out(sum_out));

  // row, bits, ded, fb, comb, pclk, poe, expected term
  typedef struct packed {
    logic [5:0] row; logic [31:0] bits; logic [7:0] ded; logic [7:0] fb;
    logic comb; logic pclk; logic poe; logic exp;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{6'd0,  32'h0000_0000, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
    '{6'd9,  32'h0000_0081, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R1
    '{6'd18, 32'h0000_0081, 8'h09, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
    '{6'd27, 32'h0010_0000, 8'h00, 8'h04, 1'b0, 1'b0, 1'b0, 1'b1}, // R1
    '{6'd36, 32'h4000_0000, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R5
    '{6'd45, 32'h4000_0000, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
    '{6'd54, 32'h0002_0000, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    '{6'd63, 32'h0000_0030, 8'h04, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}  // R4
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_row(logic [5:0] r, logic [31:0] b, logic en);
    @(negedge clk);
    cfg_row = r; cfg_bits = b; prog_en = en; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0; prog_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 terms", term_out, 64'h0);
    check("R6 sums", {56'h0, sum_out}, 64'h0);
    check("R7 ready", {63'h0, cfg_ready}, 64'h1);

    for (int i = 0; i < 8; i++) begin
      write_row(VECS[i].row, VECS[i].bits, 1'b1);
      ded_in = VECS[i].ded; fb_in = VECS[i].fb; comb_mode = VECS[i].comb;
      pin_clk_in = VECS[i].pclk; pin_oe_in = VECS[i].poe;
      #1;
      check("R7 table term", {63'h0, term_out[VECS[i].row]}, {63'h0, VECS[i].exp});
      check("R2 table sum", {63'h0, sum_out[VECS[i].row / 8]}, {63'h0, VECS[i].exp});
    end

    // R8: disabled write to row 0 (empty, reads 1) must not connect columns
    write_row(6'd0, 32'hFFFF_FFFF, 1'b0);
    ded_in = 8'h00; fb_in = 8'h00; comb_mode = 1'b0; #1;
    check("R8 locked row", {63'h0, term_out[0]}, 64'h1);

    // R9: row 9 = ded0 & ~ded3, changes without a clock edge
    @(negedge clk); ded_in = 8'h01; #1;
    check("R9 comb high", {63'h0, term_out[9]}, 64'h1);
    ded_in = 8'h00; #1;
    check("R9 comb low", {63'h0, term_out[9]}, 64'h0);

    // R5: with comb_mode=0 the clock pin is ignored, fb7 used
    comb_mode = 1'b0; pin_clk_in = 1'b1; fb_in = 8'h00; #1;
    check("R5 pin ignored", {63'h0, term_out[36]}, 64'h0);
    fb_in = 8'h80; #1;
    check("R5 fb7 used", {63'h0, term_out[36]}, 64'h1);

    // R1: fb0 true is column 16
    write_row(6'd10, 32'h0001_0000, 1'b1);
    fb_in = 8'h01; #1;
    check("R1 fb0 col16", {63'h0, term_out[10]}, 64'h1);
    fb_in = 8'h00; #1;
    check("R1 fb0 low", {63'h0, term_out[10]}, 64'h0);

    // R2: group 7 sum reflects only its own rows
    check("R2 group7", {63'h0, sum_out[7]}, 64'h0);
    write_row(6'd60, 32'h0, 1'b1); #1;
    check("R2 group7 set", {63'h0, sum_out[7]}, 64'h1);

    // R6: reset restores the fully connected matrix
    rst_n = 1'b0; #1;
    check("R6 reset again", term_out, 64'h0);
    rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule